// File: doc/BRIEF.md
# Slot-Based PWM Generator

This block drives a single pulse-width-modulated line. The line's period is a frame of eight slots, and each slot lasts one clock cycle. A 3-bit duty code gives the number of slots at the head of each frame during which the line is held low. The line is high for every remaining slot of the frame. Frames follow one another with no gap.

The duty code is taken at the first slot of each frame and held for the rest of that frame. A change made partway through a frame therefore takes effect at the next frame boundary.

An active-low synchronous reset holds the output low and returns the slot position to the frame start. The first edge with reset released is slot 0 of a new frame.

Top module: `slot_pwm`

## Requirements
- R1: While rst_n is sampled low on a rising clock edge, pwm_o is 0 after that edge. The frame position returns to slot 0.
- R2: A frame is exactly 8 slots of one clock cycle each. Frames repeat back to back, so the output pattern has a period of 8 cycles for a constant duty code.
- R3: For a duty code D (an unsigned 3-bit value on duty_i), pwm_o is 0 after the first D edges of the frame (slots 0 to D-1).
- R4: After those low slots, pwm_o is 1 for the remaining 8-D slots (slots D to 7).
- R5: The first rising edge with rst_n high is slot 0 of a frame. After that edge, pwm_o already shows slot 0's level.
- R6: A duty code of 0 gives a high output in all 8 slots of the frame.
- R7: A duty code of 7 gives 7 low slots followed by a single high slot in slot 7.
- R8: duty_i is sampled only on the edge of slot 0. Changes to duty_i during slots 1 to 7 do not alter that frame's output, and apply from the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock; one cycle per slot |
| rst_n | input | 1 | Synchronous reset, active low |
| duty_i | input | 3 | Number of low slots at the start of the frame |
| pwm_o | output | 1 | Registered PWM output |

## Verification
Every result of this block appears one clock edge after it is decided. The level for slot k is visible right after the k-th edge of the frame, counted from 0. The edge where reset is sampled low forces a 0 that is visible right after that same edge.

The bench changes duty_i and rst_n only on falling edges. It samples pwm_o on the next falling edge and compares it with (k >= D), where D is the code the bench applied before slot 0. Mid-frame duty changes are made on the falling edge after a sample, so the sample that follows shows whether the change leaked into the current frame.

// File: rtl/slot_pwm_pkg.sv
package slot_pwm_pkg;
    // Width of the slot index; the frame holds 2**SLOT_W slots.
    localparam int SLOT_W    = 3;
    localparam int NUM_SLOTS = 1 << SLOT_W;
    localparam int LAST_SLOT = NUM_SLOTS - 1;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        slot_t pos;
    } cnt_state_t;

    typedef struct packed {
        slot_t code;
    } duty_state_t;

    typedef struct packed {
        logic level;
    } out_state_t;
endpackage

// File: rtl/pwm_slot_counter.sv
module pwm_slot_counter
    import slot_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_t slot_o,
    output logic  frame_start_o
);
    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Power-of-two frame: the increment wraps from the last slot to 0.
        st_d.pos = st_q.pos + slot_t'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_o        = st_q.pos;
    assign frame_start_o = (st_q.pos == '0);
endmodule

// File: rtl/pwm_duty_latch.sv
module pwm_duty_latch
    import slot_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  frame_start_i,
    input  slot_t duty_i,
    output slot_t duty_eff_o,
    output slot_t duty_hold_o
);
    duty_state_t st_d, st_q;
    slot_t       eff;

    always_comb begin
        // Slot 0 uses the live input; later slots use the held copy.
        eff       = frame_start_i ? duty_i : st_q.code;
        st_d      = st_q;
        st_d.code = eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign duty_eff_o  = eff;
    assign duty_hold_o = st_q.code;
endmodule

// File: rtl/pwm_level_reg.sv
module pwm_level_reg
    import slot_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t slot_i,
    input  slot_t duty_i,
    output logic  level_o
);
    out_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        // Low while the slot index is below the duty code, high afterwards.
        st_d.level = (slot_i >= duty_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;
endmodule

// File: rtl/slot_pwm.sv
module slot_pwm
    import slot_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] duty_i,
    output logic              pwm_o
);
    slot_t slot_w;
    logic  frame_start_w;
    slot_t duty_eff_w;
    slot_t duty_hold_w;

    pwm_slot_counter u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .slot_o        (slot_w),
        .frame_start_o (frame_start_w)
    );

    pwm_duty_latch u_duty (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_w),
        .duty_i        (duty_i),
        .duty_eff_o    (duty_eff_w),
        .duty_hold_o   (duty_hold_w)
    );

    pwm_level_reg u_lvl (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot_i  (slot_w),
        .duty_i  (duty_eff_w),
        .level_o (pwm_o)
    );
endmodule

// File: rtl/slot_pwm_chk.sv
module slot_pwm_chk
    import slot_pwm_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input slot_t duty_i,
    input logic  pwm_o,
    input slot_t slot_w,
    input slot_t duty_hold_w
);
    // R1: an edge with reset low leaves the output at 0 and the slot at 0.
    p_rst_low_r1: assert property (@(posedge clk)
        !rst_n |=> (!pwm_o && slot_w == '0));

    // R2: the slot index advances by one and wraps after the last slot.
    p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_w == slot_t'(LAST_SLOT)) |=> (slot_w == '0));

    // R7 / R4: the last slot of every frame is high.
    p_last_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_w == slot_t'(LAST_SLOT)) |=> pwm_o);

    // R6: a zero duty code at the frame start gives a high first slot.
    p_zero_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_w == '0 && duty_i == '0) |=> pwm_o);

    // R3 / R5: a nonzero duty code at the frame start gives a low first slot.
    p_first_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_w == '0 && duty_i != '0) |=> !pwm_o);

    // R8: the held duty code changes only on the frame-start edge.
    p_duty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_w != '0) |=> $stable(duty_hold_w));
endmodule

bind slot_pwm slot_pwm_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .duty_i      (duty_i),
    .pwm_o       (pwm_o),
    .slot_w      (slot_w),
    .duty_hold_w (duty_hold_w)
);

// File: tb/slot_pwm_tb.sv
module slot_pwm_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] duty = 3'd0;
    logic       pwm;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;   // 50 MHz

    slot_pwm u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .duty_i (duty),
        .pwm_o  (pwm)
    );

    function automatic logic exp_level(int slot, int d);
        return (slot >= d);
    endfunction

    task automatic check(logic exp, string req, int slot, int d);
        n_checks++;
        if (pwm !== exp) begin
            n_fail++;
            $display("FAIL %s slot=%0d duty=%0d actual=%b expected=%b",
                     req, slot, d, pwm, exp);
        end
    endtask

    // Runs one frame with code d. If chg_at >= 0, duty_i is set to chg_val
    // after the sample of slot chg_at. The caller sets duty before slot 0.
    task automatic run_frame(int d, int chg_at, int chg_val, string req);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(exp_level(k, d), req, k, d);
            if (k == chg_at) duty = 3'(chg_val);
        end
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: output held low during reset
        duty = 3'd5;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(1'b0, "R1", 0, 5);
        end
        // R5: frame begins on the first edge with reset high
        duty  = 3'd3;
        rst_n = 1'b1;
        run_frame(3, -1, 0, "R5");
        // R6, R7 corners
        duty = 3'd0; run_frame(0, -1, 0, "R6");
        duty = 3'd7; run_frame(7, -1, 0, "R7");
        // R2: all codes, back to back, twice for periodicity
        for (int d = 0; d < 8; d++) begin
            duty = 3'(d); run_frame(d, -1, 0, "R2");
            duty = 3'(d); run_frame(d, -1, 0, "R2");
        end
        // R8: mid-frame change ignored, applied next frame
        duty = 3'd2; run_frame(2, 3, 6, "R8");
        run_frame(6, -1, 0, "R8");
        duty = 3'd7; run_frame(7, 0, 0, "R8");
        run_frame(0, -1, 0, "R8");
        // R3 / R4: random codes with random mid-frame disturbance
        for (int i = 0; i < 200; i++) begin
            int d = int'($urandom_range(0, 7));
            int c = int'($urandom_range(0, 6));
            int v = int'($urandom_range(0, 7));
            duty = 3'(d);
            run_frame(d, c, v, (d % 2 == 0) ? "R3" : "R4");
        end
        // R1: reset in the middle of a frame
        duty = 3'd1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(exp_level(k, 1), "R4", k, 1);
        end
        rst_n = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(1'b0, "R1", 0, 1);
        end
        duty  = 3'd4;
        rst_n = 1'b1;
        run_frame(4, -1, 0, "R1");
        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule